// File: doc/BRIEF.md
# Six-Operation Single-Cycle Integer Core

This block is a small processor core that completes one instruction every clock cycle. It fetches a 32-bit instruction word from an external instruction memory at the byte address held in its program counter. It decodes the word in the register and immediate layouts and reads two operands from a 32-entry register file. A shared adder/subtractor produces either an arithmetic result or a memory address. The result is written back or used to decide a conditional branch, all in the same cycle.

Six operations are understood: register add, register subtract, word load, word store, branch-if-equal and branch-if-different. Data memory is byte-addressed and big-endian, and it is reached through a word-wide port with a combinational read. An operation outside the subset, or a data access whose address is not a multiple of four, stops the core. The core latches a halt flag, freezes the program counter and suppresses the faulting instruction's side effects until the next reset. A surrounding test harness or system controller uses this flag to detect the end of a program or a fault.

Top module: `sixop_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter becomes 0 and `halt` becomes 0. After reset, `imem_addr` reads 0.
- R2: An instruction with bits [31:26] = 0 and bits [5:0] = 0x20 writes the sum of the registers named by bits [25:21] and [20:16] into the register named by bits [15:11].
- R3: Bits [31:26] = 0 with bits [5:0] = 0x22 writes the first operand minus the second into the register named by bits [15:11]. The result wraps modulo 2^32 and does not trap.
- R4: Register 0 always reads as zero. Any write that names it as the destination is dropped.
- R5: Bits [31:26] = 0x23 loads the word at the sign-extended bits [15:0] plus the register named by bits [25:21] into the register named by bits [20:16].
- R6: Bits [31:26] = 0x2B stores the register named by bits [20:16] at the address formed as in R5. Bytes are big-endian: `dmem_wdata[31:24]` and `dmem_rdata[31:24]` are the byte at the word address itself.
- R7: Bits [31:26] = 0x04 branches when both source registers are equal. The target is PC + 4 + (sign-extended bits [15:0] shifted left by 2). Otherwise the PC steps to PC + 4.
- R8: Bits [31:26] = 0x05 branches to the same target as R7 when the two source registers differ. Otherwise the PC steps to PC + 4.
- R9: Add, subtract, load and store advance the PC by 4. The PC is always a multiple of 4.
- R10: Any other opcode, or opcode 0 with a function field other than 0x20 or 0x22, sets `halt`. That instruction makes no register or memory write, and the PC stays on its address.
- R11: A load or store whose computed address has non-zero bits [1:0] sets `halt`. It performs no memory access or register write, and the PC stays put.
- R12: Once set, `halt` stays high and the PC stays frozen, with no further memory writes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, big-endian byte order |
| dmem_we | output | 1 | Write strobe for a word store at the next rising edge |
| dmem_re | output | 1 | Read strobe for a word load |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational, big-endian |
| halt | output | 1 | Sticky stop flag for an unsupported instruction or a misaligned access |

## Verification
Register contents are only visible at the ports when a store writes them out. Every arithmetic, zero-register and sign-extension result is therefore checked by a short program that computes a value and then stores it to a known memory word, which the bench reads back byte by byte. Taken and untaken branches are distinguished by marker stores placed on the skipped and the executed paths, combined with the final frozen PC. The halt cases are reached by ending each program with a deliberately bad word. The bench then checks that the store following a faulting one never reaches memory.

// File: rtl/sixop_pkg.sv
// Shared encodings and control bundle for the six-operation core.
// Assumes the fixed 32-bit instruction layout; opcode values are architectural.
package sixop_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE  = 6'h00;
    localparam logic [5:0] OP_LOADW  = 6'h23;
    localparam logic [5:0] OP_STOREW = 6'h2B;
    localparam logic [5:0] OP_BREQ   = 6'h04;
    localparam logic [5:0] OP_BRNE   = 6'h05;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic     reg_we;     // instruction writes a register
        logic     dst_is_rd;  // destination is bits [15:11] (else [20:16])
        logic     load;       // word load
        logic     store;      // word store
        logic     use_imm;    // second ALU operand is the extended immediate
        logic     sub;        // ALU subtracts
        br_kind_e br;         // branch condition
        logic     illegal;    // outside the supported subset
    } ctrl_t;
endpackage

// File: rtl/sixop_decode.sv
// Instruction decoder: splits the word into fields and builds the control bundle.
// Assumes: purely combinational; any encoding not in the subset raises illegal.
module sixop_decode
    import sixop_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [31:0]  instr,
    output ctrl_t        ctrl,
    output logic [4:0]   rs,
    output logic [4:0]   rt,
    output logic [4:0]   rd,
    output logic [W-1:0] imm_ext
);
    localparam int IMM_W = 16;

    logic [5:0] opcode;
    logic [5:0] fn;

    assign opcode  = instr[31:26];
    assign fn      = instr[5:0];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign imm_ext = {{(W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    // Map opcode and function code onto control signals.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, load: 1'b0, store: 1'b0,
                 use_imm: 1'b0, sub: 1'b0, br: BR_NONE, illegal: 1'b0};
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                if (fn == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                end else if (fn == FN_SUB) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.sub    = 1'b1;
                end else begin
                    ctrl.illegal = 1'b1;
                end
            end
            OP_LOADW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.load    = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_STOREW: begin
                ctrl.store   = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_BREQ: begin
                ctrl.sub = 1'b1;
                ctrl.br  = BR_EQ;
            end
            OP_BRNE: begin
                ctrl.sub = 1'b1;
                ctrl.br  = BR_NE;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sixop_regfile.sv
// Register file: NREG words of W bits, two combinational reads, one write.
// Assumes: entry 0 is a constant zero and is never stored; synchronous active-low reset.
module sixop_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);
    logic [NREG-1:0][W-1:0] bank;

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign bank[i] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            // Hold one register; load it when addressed by an enabled write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (waddr == AW'(i))) begin
                    q <= wdata;
                end
            end
            assign bank[i] = q;
        end
    end

    assign rd1 = bank[ra1];
    assign rd2 = bank[ra2];
endmodule

// File: rtl/sixop_alu.sv
// Add/subtract unit shared by arithmetic, address generation and branch compare.
// Assumes: two's-complement wrap, no overflow detection.
module sixop_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] b_eff;

    // Invert the second operand and add one for a subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + W'(sub);
        zero  = (y == '0);
    end
endmodule

// File: rtl/sixop_core.sv
// Single-cycle core top: PC, fetch, decode, register file, ALU, memory port, halt.
// Assumes: instruction and data memories answer combinationally within the cycle;
// data memory writes on the rising edge when dmem_we is high.
module sixop_core
    import sixop_pkg::*;
#(
    parameter int XW   = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] imem_addr,
    input  logic [31:0]   imem_data,
    output logic [XW-1:0] dmem_addr,
    output logic [XW-1:0] dmem_wdata,
    output logic          dmem_we,
    output logic          dmem_re,
    input  logic [XW-1:0] dmem_rdata,
    output logic          halt
);
    logic [XW-1:0] pc_q;
    logic          halt_q;
    ctrl_t         ctrl;
    logic [4:0]    f_rs, f_rt, f_rd;
    logic [XW-1:0] imm_ext;
    logic [XW-1:0] op_a, op_b_reg, op_b;
    logic [XW-1:0] alu_y;
    logic          alu_zero;
    logic          misalign, fault, run, take;
    logic [XW-1:0] pc_seq, pc_tgt;
    logic [XW-1:0] wb_data;
    logic [AW-1:0] wb_addr;

    sixop_decode #(.W(XW)) u_dec (
        .instr   (imem_data),
        .ctrl    (ctrl),
        .rs      (f_rs),
        .rt      (f_rt),
        .rd      (f_rd),
        .imm_ext (imm_ext)
    );

    sixop_regfile #(.W(XW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.reg_we && run),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (AW'(f_rs)),
        .rd1   (op_a),
        .ra2   (AW'(f_rt)),
        .rd2   (op_b_reg)
    );

    sixop_alu #(.W(XW)) u_alu (
        .a    (op_a),
        .b    (op_b),
        .sub  (ctrl.sub),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Operand select, fault detection, write-back and next-PC selection.
    always_comb begin
        op_b     = ctrl.use_imm ? imm_ext : op_b_reg;
        misalign = (ctrl.load || ctrl.store) && (alu_y[1:0] != 2'b00);
        fault    = ctrl.illegal || misalign;
        run      = !halt_q && !fault;
        wb_addr  = ctrl.dst_is_rd ? AW'(f_rd) : AW'(f_rt);
        wb_data  = ctrl.load ? dmem_rdata : alu_y;
        pc_seq   = pc_q + XW'(STEP);
        pc_tgt   = pc_seq + (imm_ext << 2);
        take     = ((ctrl.br == BR_EQ) && alu_zero) ||
                   ((ctrl.br == BR_NE) && !alu_zero);
    end

    // Program counter: cleared by reset, frozen while halted or faulting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= take ? pc_tgt : pc_seq;
        end
    end

    // Sticky halt flag: set by any fault, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (fault) begin
            halt_q <= 1'b1;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = op_b_reg;
    assign dmem_we    = ctrl.store && run;
    assign dmem_re    = ctrl.load && run;
    assign halt       = halt_q;
endmodule

// File: rtl/sixop_core_chk.sv
// Port-level temporal checks for sixop_core, attached by bind.
module sixop_core_chk #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [XW-1:0] imem_addr,
    input logic [31:0]   imem_data,
    input logic [XW-1:0] dmem_addr,
    input logic          dmem_we,
    input logic          dmem_re,
    input logic          halt
);
    p_pc_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

    p_add_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && imem_data[31:26] == 6'h00 && imem_data[5:0] == 6'h20)
        |=> imem_addr == $past(imem_addr) + XW'(4));

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    p_pc_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(imem_addr));

    p_no_store_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !dmem_we);

    p_store_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we || dmem_re) |-> dmem_addr[1:0] == 2'b00);

    p_bad_op_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[31:26] == 6'h3F) |=> halt);

    p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));
endmodule

bind sixop_core sixop_core_chk #(.XW(XW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_addr (dmem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re),
    .halt      (halt)
);

// File: tb/sixop_core_test.sv
// Directed bench: each task loads a program, runs it and checks memory, PC and halt.
module sixop_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re, halt;

    logic [31:0] imem [64];
    logic [7:0]  dmem [256];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sixop_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata),
        .halt       (halt)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = {dmem[dmem_addr[7:0]], dmem[dmem_addr[7:0] + 8'd1],
                         dmem[dmem_addr[7:0] + 8'd2], dmem[dmem_addr[7:0] + 8'd3]};

    always @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_addr[7:0]]        <= dmem_wdata[31:24];
            dmem[dmem_addr[7:0] + 8'd1] <= dmem_wdata[23:16];
            dmem[dmem_addr[7:0] + 8'd2] <= dmem_wdata[15:8];
            dmem[dmem_addr[7:0] + 8'd3] <= dmem_wdata[7:0];
        end
    end

    function automatic logic [31:0] r_ins(input int s, input int t, input int d, input logic [5:0] fn);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_ins(input logic [5:0] op, input int s, input int t, input logic [15:0] imm);
        return {op, 5'(s), 5'(t), imm};
    endfunction

    localparam logic [31:0] BAD = 32'hFC00_0000;

    task automatic put_word(input int a, input logic [31:0] v);
        dmem[a] = v[31:24]; dmem[a+1] = v[23:16]; dmem[a+2] = v[15:8]; dmem[a+3] = v[7:0];
    endtask

    function automatic logic [31:0] get_word(input int a);
        return {dmem[a], dmem[a+1], dmem[a+2], dmem[a+3]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) imem[i] = BAD;
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        clear_mem();
        do_reset();
        check(imem_addr == 32'd0, "R1 pc", imem_addr, 32'd0);
        check(halt == 1'b0, "R1 halt", 32'(halt), 32'd0);
    endtask

    // R2 R3 R4 R5 R6: arithmetic, zero register, loads, stores, byte order
    task automatic t_arith();
        clear_mem();
        put_word(8'h10, 32'd5);
        put_word(8'h14, 32'd7);
        put_word(8'h18, 32'h34);
        put_word(8'h28, 32'hDEADBEEF);
        put_word(8'h30, 32'hCAFEF00D);
        imem[0]  = i_ins(6'h23, 0, 1, 16'h0010);
        imem[1]  = i_ins(6'h23, 0, 2, 16'h0014);
        imem[2]  = r_ins(1, 2, 3, 6'h20);
        imem[3]  = r_ins(1, 2, 4, 6'h22);
        imem[4]  = i_ins(6'h2B, 0, 3, 16'h0020);
        imem[5]  = i_ins(6'h2B, 0, 4, 16'h0024);
        imem[6]  = r_ins(1, 2, 0, 6'h20);
        imem[7]  = i_ins(6'h2B, 0, 0, 16'h0028);
        imem[8]  = i_ins(6'h23, 0, 6, 16'h0018);
        imem[9]  = i_ins(6'h23, 6, 5, 16'hFFFC);
        imem[10] = i_ins(6'h2B, 0, 5, 16'h002C);
        do_reset();
        step(3);
        check(imem_addr == 32'd12 && !halt, "R9 sequential pc", imem_addr, 32'd12);
        step(12);
        check(get_word(8'h20) == 32'd12, "R2 add", get_word(8'h20), 32'd12);
        check(get_word(8'h24) == 32'hFFFF_FFFE, "R3 sub wrap", get_word(8'h24), 32'hFFFF_FFFE);
        check(get_word(8'h28) == 32'd0, "R4 zero reg", get_word(8'h28), 32'd0);
        check(get_word(8'h2C) == 32'hCAFEF00D, "R5 negative offset load", get_word(8'h2C), 32'hCAFEF00D);
        check(dmem[8'h2C] == 8'hCA, "R6 msb at word address", 32'(dmem[8'h2C]), 32'hCA);
        check(dmem[8'h23] == 8'h0C, "R6 lsb at address+3", 32'(dmem[8'h23]), 32'h0C);
        check(halt && imem_addr == 32'd44, "R10 bad opcode stops", imem_addr, 32'd44);
    endtask

    // R7 R8: taken and untaken branches in both senses
    task automatic t_branch();
        clear_mem();
        put_word(8'h10, 32'd3);
        put_word(8'h14, 32'd3);
        put_word(8'h18, 32'd4);
        for (int a = 8'h40; a < 8'h54; a += 4) put_word(a, 32'h1111_1111);
        imem[0]  = i_ins(6'h23, 0, 1, 16'h0010);
        imem[1]  = i_ins(6'h23, 0, 2, 16'h0014);
        imem[2]  = i_ins(6'h04, 1, 2, 16'h0002);
        imem[3]  = i_ins(6'h2B, 0, 1, 16'h0040);
        imem[4]  = i_ins(6'h2B, 0, 1, 16'h0044);
        imem[5]  = i_ins(6'h05, 1, 2, 16'h0001);
        imem[6]  = i_ins(6'h2B, 0, 2, 16'h0048);
        imem[7]  = i_ins(6'h23, 0, 3, 16'h0018);
        imem[8]  = i_ins(6'h04, 1, 3, 16'h0001);
        imem[9]  = i_ins(6'h2B, 0, 3, 16'h004C);
        imem[10] = i_ins(6'h05, 1, 3, 16'h0001);
        imem[11] = i_ins(6'h2B, 0, 3, 16'h0050);
        do_reset();
        step(15);
        check(get_word(8'h40) == 32'h1111_1111, "R7 beq taken skips", get_word(8'h40), 32'h1111_1111);
        check(get_word(8'h44) == 32'h1111_1111, "R7 beq taken skips second", get_word(8'h44), 32'h1111_1111);
        check(get_word(8'h48) == 32'd3, "R8 bne untaken falls through", get_word(8'h48), 32'd3);
        check(get_word(8'h4C) == 32'd4, "R7 beq untaken falls through", get_word(8'h4C), 32'd4);
        check(get_word(8'h50) == 32'h1111_1111, "R8 bne taken skips", get_word(8'h50), 32'h1111_1111);
        check(halt && imem_addr == 32'd48, "R8 final pc", imem_addr, 32'd48);
    endtask

    // R11 R12: misaligned store halts, blocks its write and everything after
    task automatic t_misalign();
        clear_mem();
        put_word(8'h10, 32'd7);
        put_word(8'h20, 32'hA5A5_A5A5);
        imem[0] = i_ins(6'h23, 0, 1, 16'h0010);
        imem[1] = i_ins(6'h2B, 0, 1, 16'h0022);
        imem[2] = i_ins(6'h2B, 0, 1, 16'h0030);
        do_reset();
        step(4);
        check(halt == 1'b1, "R11 misaligned halts", 32'(halt), 32'd1);
        check(imem_addr == 32'd4, "R11 pc held", imem_addr, 32'd4);
        step(10);
        check(halt && imem_addr == 32'd4, "R12 stays halted", imem_addr, 32'd4);
        check(get_word(8'h20) == 32'hA5A5_A5A5, "R11 no write", get_word(8'h20), 32'hA5A5_A5A5);
        check(get_word(8'h30) == 32'd0, "R12 later store blocked", get_word(8'h30), 32'd0);
    endtask

    // R10 R12: unsupported function code halts; reset clears halt
    task automatic t_bad_funct();
        clear_mem();
        put_word(8'h10, 32'd9);
        imem[0] = i_ins(6'h23, 0, 1, 16'h0010);
        imem[1] = r_ins(1, 1, 2, 6'h21);
        imem[2] = i_ins(6'h2B, 0, 1, 16'h0030);
        do_reset();
        step(6);
        check(halt && imem_addr == 32'd4, "R10 bad funct halts", imem_addr, 32'd4);
        check(get_word(8'h30) == 32'd0, "R10 no later store", get_word(8'h30), 32'd0);
        do_reset();
        check(!halt && imem_addr == 32'd0, "R12 reset clears halt", 32'(halt), 32'd0);
        // R11: misaligned load also halts and writes nothing back
        imem[0] = i_ins(6'h23, 0, 1, 16'h0011);
        imem[1] = i_ins(6'h2B, 0, 1, 16'h0030);
        do_reset();
        step(5);
        check(halt && imem_addr == 32'd0, "R11 misaligned load halts", imem_addr, 32'd0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_branch();
        t_misalign();
        t_bad_funct();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule